// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block is a synchronous state machine, clocked by the bus clock, that decides when a processor core may run and when its clocks are held off. It tracks five architectural power states: Normal, Halt Powerdown, Stop-Grant, a snoop-service sub-state and Sleep. Two internal waypoints sit on the road into Stop-Grant: one where an acknowledge request is outstanding, and one where a fixed delay runs.

A halt strobe from the core parks it in Halt Powerdown. The platform uses an active-low stop-clock request and an active-low sleep request to push the core deeper. The block asks the bus logic to issue the stop-grant acknowledge and waits for its response phase before the timed entry starts. Snoops are serviced from the halted and granted states. Events that arrive while clocks are stopped are held and handed over once the core runs again. Misuse of the request pins raises a one-cycle illegal-condition pulse.

Top module: `lps_ctrl`

## Requirements
- R1: State codes on `state_o` are Normal=0, Halt=1, Stop-Grant=2, Snoop=3, Sleep=4, acknowledge-wait=5 and entry-delay=6. After `rst_n`, the state is Normal with `core_clk_en_o`=1 and every other output 0. `core_clk_en_o` is 1 only in Normal, and `snoop_en_o` is 1 only in Snoop.
- R2: `halt_stb_i` in Normal gives Halt on the next cycle. Halt returns to Normal when any one of `smi_i`, `init_i`, `nmi_i`, `intr_i`, `bus_irq_i` or `binit_i` is sampled.
- R3: `stpclk_n_i` low in Normal or Halt moves to acknowledge-wait. `sga_req_o` stays high there until `sga_resp_i` is sampled. The state then reads entry-delay, and it reads Stop-Grant exactly 20 rising edges after the edge that sampled the response.
- R4: In Stop-Grant, `stpclk_n_i` high leads to Normal if the entry began in Normal, and to Halt if it began in Halt.
- R5: `slp_n_i` low in Stop-Grant gives Sleep. `slp_n_i` has no effect in Normal or in Halt. `slp_n_i` high in Sleep returns to Stop-Grant.
- R6: `snoop_hit_i` in Halt or Stop-Grant gives Snoop. Snoop holds until `snoop_done_i`, then returns to the state it was entered from.
- R7: In Stop-Grant the events are latched into `svc_o` bits: bit 0 SMI, bit 1 INIT, bit 2 bus-init, bit 3 NMI or INTR. Repeats of an event collapse into one bit. The bits show for exactly one cycle, the first cycle back in Normal, and are 0 at all other times.
- R8: While `binit_i` is high in Stop-Grant, a release of stop-clock is held off. When bus-init ends, the block goes to Normal if stop-clock is released and otherwise stays in Stop-Grant.
- R9: `core_reset_i` in Stop-Grant keeps the state and clears both the latched events and the Halt origin, so a later release leads to Normal. In any other state, including Sleep, it gives Normal on the next cycle.
- R10: In Sleep, events and snoops are not latched. Any input activity in Sleep other than `slp_n_i` rising or `core_reset_i` pulses `illegal_o`. This includes stop-clock released in the same cycle as the sleep request. A snoop in the cycle that enters Sleep also pulses `illegal_o`. The pulse shows with the state update of that edge.
- R11: A release of stop-clock during acknowledge-wait or entry-delay pulses `illegal_o` for one cycle, and the entry carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_stb_i | input | 1 | Halt instruction strobe from the core |
| stpclk_n_i | input | 1 | Stop-clock request, active low |
| slp_n_i | input | 1 | Sleep request, active low |
| sga_resp_i | input | 1 | Response phase of the acknowledge cycle done |
| snoop_hit_i | input | 1 | Snoop seen on the system bus |
| snoop_done_i | input | 1 | Snoop serviced by any agent |
| smi_i | input | 1 | System management interrupt event |
| init_i | input | 1 | Init event |
| nmi_i | input | 1 | Local non-maskable interrupt line |
| intr_i | input | 1 | Local maskable interrupt line |
| bus_irq_i | input | 1 | Interrupt delivered over the bus |
| binit_i | input | 1 | Bus initialization in progress |
| core_reset_i | input | 1 | Synchronous processor reset event |
| state_o | output | 3 | Current state code |
| sga_req_o | output | 1 | Request to issue the stop-grant acknowledge |
| core_clk_en_o | output | 1 | Core clock enable |
| snoop_en_o | output | 1 | Snoop service enable |
| svc_o | output | 4 | Latched events presented for service |
| illegal_o | output | 1 | Illegal-condition pulse |

## Verification
Every state change, the acknowledge request and the illegal pulse follow the sampling edge by one register. So each stimulus cycle has one expected entry, and that entry is compared 2 ns after the next rising edge. The Stop-Grant entry is checked at all 20 intermediate edges: after the response edge, the bench expects entry-delay 19 more times and then Stop-Grant. `svc_o` is combinational from registered state, so the bench expects it in the same entry as the first Normal state and zero in the entry after that.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_HALT   = 3'd1,
        ST_GRANT  = 3'd2,
        ST_SNOOP  = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_ACKW   = 3'd5,
        ST_ENTRY  = 3'd6
    } lps_state_e;

    localparam int EVT_W    = 4;
    localparam int EVT_SMI  = 0;
    localparam int EVT_INIT = 1;
    localparam int EVT_BINI = 2;
    localparam int EVT_LINT = 3;

    typedef struct packed {
        lps_state_e st;
        logic       from_halt;
        lps_state_e snp_ret;
        logic       illegal;
    } lps_regs_t;

endpackage

// File: rtl/lps_entry_timer.sv
module lps_entry_timer #(
    parameter int DELAY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(DELAY - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = tmr_q.run && (tmr_q.cnt == '0);

    // R3: the count never leaves its window.
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt < CW'(DELAY)));

    // R3: the expiry is a single cycle unless the timer is restarted.
    a_r3_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !start_i) |=> !expired_o);

endmodule

// File: rtl/lps_pend_latch.sv
module lps_pend_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic         present_i,
    input  logic         clear_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] svc_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clear_i || present_i) begin
            pend_d = '0;
        end else if (capture_i) begin
            pend_d = pend_q | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign svc_o = present_i ? pend_q : '0;

    // R7: a presentation never repeats on the next cycle.
    a_r7_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_o != '0) |=> (svc_o == '0));

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int ENTRY_DELAY = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_stb_i,
    input  logic             stpclk_n_i,
    input  logic             slp_n_i,
    input  logic             sga_resp_i,
    input  logic             snoop_hit_i,
    input  logic             snoop_done_i,
    input  logic             smi_i,
    input  logic             init_i,
    input  logic             nmi_i,
    input  logic             intr_i,
    input  logic             bus_irq_i,
    input  logic             binit_i,
    input  logic             core_reset_i,
    output logic [2:0]       state_o,
    output logic             sga_req_o,
    output logic             core_clk_en_o,
    output logic             snoop_en_o,
    output logic [EVT_W-1:0] svc_o,
    output logic             illegal_o
);
    lps_regs_t        r_d, r_q;
    logic             tmr_start, tmr_expired;
    logic             wake_evt;
    logic [EVT_W-1:0] evt_vec;

    assign wake_evt = smi_i | init_i | nmi_i | intr_i | bus_irq_i | binit_i;

    always_comb begin
        evt_vec           = '0;
        evt_vec[EVT_SMI]  = smi_i;
        evt_vec[EVT_INIT] = init_i;
        evt_vec[EVT_BINI] = binit_i;
        evt_vec[EVT_LINT] = nmi_i | intr_i;
    end

    always_comb begin
        r_d         = r_q;
        r_d.illegal = 1'b0;
        tmr_start   = 1'b0;
        if (core_reset_i) begin
            r_d.from_halt = 1'b0;
        end
        case (r_q.st)
            ST_NORMAL: begin
                if (!core_reset_i) begin
                    if (!stpclk_n_i) begin
                        r_d.st        = ST_ACKW;
                        r_d.from_halt = 1'b0;
                    end else if (halt_stb_i) begin
                        r_d.st = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (core_reset_i || wake_evt) begin
                    r_d.st = ST_NORMAL;
                end else if (snoop_hit_i) begin
                    r_d.st      = ST_SNOOP;
                    r_d.snp_ret = ST_HALT;
                end else if (!stpclk_n_i) begin
                    r_d.st        = ST_ACKW;
                    r_d.from_halt = 1'b1;
                end
            end
            ST_ACKW: begin
                if (core_reset_i) begin
                    r_d.st = ST_NORMAL;
                end else begin
                    r_d.illegal = stpclk_n_i;
                    if (sga_resp_i) begin
                        r_d.st    = ST_ENTRY;
                        tmr_start = 1'b1;
                    end
                end
            end
            ST_ENTRY: begin
                if (core_reset_i) begin
                    r_d.st = ST_NORMAL;
                end else begin
                    r_d.illegal = stpclk_n_i;
                    if (tmr_expired) begin
                        r_d.st = ST_GRANT;
                    end
                end
            end
            ST_GRANT: begin
                if (core_reset_i) begin
                    r_d.st = ST_GRANT;
                end else if (!slp_n_i) begin
                    r_d.st      = ST_SLEEP;
                    r_d.illegal = snoop_hit_i;
                end else if (snoop_hit_i) begin
                    r_d.st      = ST_SNOOP;
                    r_d.snp_ret = ST_GRANT;
                end else if (!binit_i && stpclk_n_i) begin
                    r_d.st = r_q.from_halt ? ST_HALT : ST_NORMAL;
                end
            end
            ST_SNOOP: begin
                if (core_reset_i) begin
                    r_d.st = ST_NORMAL;
                end else if (snoop_done_i) begin
                    r_d.st = r_q.snp_ret;
                end
            end
            ST_SLEEP: begin
                if (core_reset_i) begin
                    r_d.st = ST_NORMAL;
                end else begin
                    r_d.illegal = halt_stb_i | snoop_hit_i | snoop_done_i | wake_evt
                                | sga_resp_i | stpclk_n_i;
                    if (slp_n_i) begin
                        r_d.st = ST_GRANT;
                    end
                end
            end
            default: begin
                r_d.st = ST_NORMAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_NORMAL, from_halt: 1'b0, snp_ret: ST_HALT, illegal: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    lps_entry_timer #(.DELAY(ENTRY_DELAY)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .clear_i   (core_reset_i),
        .expired_o (tmr_expired)
    );

    lps_pend_latch #(.N(EVT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i ((r_q.st == ST_GRANT) && !core_reset_i),
        .present_i (r_q.st == ST_NORMAL),
        .clear_i   (core_reset_i),
        .evt_i     (evt_vec),
        .svc_o     (svc_o)
    );

    assign state_o       = r_q.st;
    assign sga_req_o     = (r_q.st == ST_ACKW);
    assign core_clk_en_o = (r_q.st == ST_NORMAL);
    assign snoop_en_o    = (r_q.st == ST_SNOOP);
    assign illegal_o     = r_q.illegal;

    // R1: running the core and servicing a snoop never overlap.
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_clk_en_o && snoop_en_o));

    // R3: the acknowledge request is held until its response arrives.
    a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sga_req_o && !sga_resp_i && !core_reset_i) |=> sga_req_o);

    // R3: Stop-Grant is reached only through the delay, a wake or a snoop return.
    a_r3_grant_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GRANT && $past(r_q.st) != ST_GRANT) |->
        ($past(r_q.st) == ST_ENTRY || $past(r_q.st) == ST_SLEEP || $past(r_q.st) == ST_SNOOP));

    // R5: Sleep is entered only from Stop-Grant.
    a_r5_sleep_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && $past(r_q.st) != ST_SLEEP) |-> ($past(r_q.st) == ST_GRANT));

    // R6: a serviced snoop lands in a low-power state.
    a_r6_snoop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_en_o && snoop_done_i && !core_reset_i) |=>
        (state_o == ST_HALT || state_o == ST_GRANT));

    // R9: reset outside Stop-Grant lands in Normal.
    a_r9_reset_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reset_i && state_o != ST_GRANT) |=> (state_o == ST_NORMAL));

endmodule

// File: tb/tb_lps_ctrl.sv
`timescale 1ns/1ps
module tb_lps_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_stb = 0, stpclk_n = 1, slp_n = 1, sga_resp = 0;
    logic       snoop_hit = 0, snoop_done = 0, smi = 0, init = 0, nmi = 0;
    logic       intr = 0, bus_irq = 0, binit = 0, core_reset = 0;
    logic [2:0] state;
    logic       sga_req, clk_en, snp_en, illegal;
    logic [3:0] svc;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    typedef struct packed {
        logic [2:0] st;
        logic       sga;
        logic [3:0] svc;
        logic       ill;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    always #10 clk = ~clk;

    lps_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_stb_i(halt_stb), .stpclk_n_i(stpclk_n),
        .slp_n_i(slp_n), .sga_resp_i(sga_resp), .snoop_hit_i(snoop_hit),
        .snoop_done_i(snoop_done), .smi_i(smi), .init_i(init), .nmi_i(nmi),
        .intr_i(intr), .bus_irq_i(bus_irq), .binit_i(binit), .core_reset_i(core_reset),
        .state_o(state), .sga_req_o(sga_req), .core_clk_en_o(clk_en),
        .snoop_en_o(snp_en), .svc_o(svc), .illegal_o(illegal)
    );

    task automatic compare(input string r, input exp_t e);
        logic ce, se;
        ce = (e.st == 3'd0);
        se = (e.st == 3'd3);
        n_chk++;
        if (state !== e.st || sga_req !== e.sga || svc !== e.svc || illegal !== e.ill
            || clk_en !== ce || snp_en !== se) begin
            n_err++;
            $display("FAIL %s t=%0t: st=%0d sga=%0b svc=%b ill=%0b cen=%0b sen=%0b expected st=%0d sga=%0b svc=%b ill=%0b cen=%0b sen=%0b",
                     r, $time, state, sga_req, svc, illegal, clk_en, snp_en,
                     e.st, e.sga, e.svc, e.ill, ce, se);
        end
    endtask

    // Monitor: one expected entry per cycle, compared after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                compare(req_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        halt_stb = 0; sga_resp = 0; snoop_hit = 0; snoop_done = 0;
        smi = 0; init = 0; nmi = 0; intr = 0; bus_irq = 0; core_reset = 0;
    endtask

    task automatic exp(input string r, input logic [2:0] st, input logic sga,
                       input logic [3:0] sv, input logic ill);
        exp_q.push_back('{st: st, sga: sga, svc: sv, ill: ill});
        req_q.push_back(r);
    endtask

    // Walk into Stop-Grant from the current Normal or Halt state.
    task automatic go_grant();
        cyc(); stpclk_n = 0; exp("R3", 3'd5, 1, 4'h0, 0);
        cyc(); exp("R3", 3'd5, 1, 4'h0, 0);
        cyc(); sga_resp = 1; exp("R3", 3'd6, 0, 4'h0, 0);
        for (int i = 1; i < 20; i++) begin
            cyc(); exp("R3", 3'd6, 0, 4'h0, 0);
        end
        cyc(); exp("R3", 3'd2, 0, 4'h0, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1", '{st: 3'd0, sga: 0, svc: 4'h0, ill: 0});
        rst_n = 1;

        // R5 ignored in Normal and Halt, R2 halt and wake
        cyc(); slp_n = 0; exp("R5", 3'd0, 0, 4'h0, 0);
        cyc(); slp_n = 1; halt_stb = 1; exp("R2", 3'd1, 0, 4'h0, 0);
        cyc(); slp_n = 0; exp("R5", 3'd1, 0, 4'h0, 0);
        cyc(); slp_n = 1; nmi = 1; exp("R2", 3'd0, 0, 4'h0, 0);
        cyc(); halt_stb = 1; exp("R2", 3'd1, 0, 4'h0, 0);
        cyc(); bus_irq = 1; exp("R2", 3'd0, 0, 4'h0, 0);

        // R3 timed entry from Normal, R7 latching, R4 release to Normal
        go_grant();
        cyc(); smi = 1; exp("R7", 3'd2, 0, 4'h0, 0);
        cyc(); smi = 1; exp("R7", 3'd2, 0, 4'h0, 0);
        cyc(); init = 1; exp("R7", 3'd2, 0, 4'h0, 0);
        cyc(); intr = 1; exp("R7", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R4", 3'd0, 0, 4'b1011, 0);
        cyc(); exp("R7", 3'd0, 0, 4'h0, 0);

        // R6 snoop from Halt and from Stop-Grant, R4 release back to Halt
        cyc(); halt_stb = 1; exp("R2", 3'd1, 0, 4'h0, 0);
        cyc(); snoop_hit = 1; exp("R6", 3'd3, 0, 4'h0, 0);
        cyc(); exp("R6", 3'd3, 0, 4'h0, 0);
        cyc(); snoop_done = 1; exp("R6", 3'd1, 0, 4'h0, 0);
        go_grant();
        cyc(); snoop_hit = 1; exp("R6", 3'd3, 0, 4'h0, 0);
        cyc(); snoop_done = 1; exp("R6", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R4", 3'd1, 0, 4'h0, 0);
        cyc(); smi = 1; exp("R2", 3'd0, 0, 4'h0, 0);

        // R5 legal sleep round trip, stop-clock released one cycle later
        go_grant();
        cyc(); slp_n = 0; exp("R5", 3'd4, 0, 4'h0, 0);
        cyc(); exp("R5", 3'd4, 0, 4'h0, 0);
        cyc(); slp_n = 1; exp("R5", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R10", 3'd0, 0, 4'h0, 0);

        // R10 interrupt during Sleep: flagged and not latched
        go_grant();
        cyc(); slp_n = 0; exp("R5", 3'd4, 0, 4'h0, 0);
        cyc(); intr = 1; exp("R10", 3'd4, 0, 4'h0, 1);
        cyc(); exp("R10", 3'd4, 0, 4'h0, 0);
        cyc(); slp_n = 1; exp("R5", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R10", 3'd0, 0, 4'h0, 0);

        // R10 snoop on Sleep entry, stop-clock released with the sleep request
        go_grant();
        cyc(); slp_n = 0; snoop_hit = 1; exp("R10", 3'd4, 0, 4'h0, 1);
        cyc(); exp("R10", 3'd4, 0, 4'h0, 0);
        cyc(); slp_n = 1; stpclk_n = 1; exp("R10", 3'd2, 0, 4'h0, 1);
        cyc(); exp("R4", 3'd0, 0, 4'h0, 0);

        // R11 early release during acknowledge wait and during the delay
        cyc(); stpclk_n = 0; exp("R3", 3'd5, 1, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R11", 3'd5, 1, 4'h0, 1);
        cyc(); stpclk_n = 0; sga_resp = 1; exp("R11", 3'd6, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R11", 3'd6, 0, 4'h0, 1);
        cyc(); stpclk_n = 0; exp("R11", 3'd6, 0, 4'h0, 0);
        for (int i = 3; i < 20; i++) begin
            cyc(); exp("R11", 3'd6, 0, 4'h0, 0);
        end
        cyc(); exp("R11", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R4", 3'd0, 0, 4'h0, 0);

        // R8 bus-init with stop-clock released during it
        go_grant();
        cyc(); binit = 1; exp("R8", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R8", 3'd2, 0, 4'h0, 0);
        cyc(); binit = 0; exp("R8", 3'd0, 0, 4'b0100, 0);
        cyc(); exp("R7", 3'd0, 0, 4'h0, 0);

        // R8 bus-init ending with stop-clock still asserted
        go_grant();
        cyc(); binit = 1; exp("R8", 3'd2, 0, 4'h0, 0);
        cyc(); binit = 0; exp("R8", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R8", 3'd0, 0, 4'b0100, 0);

        // R9 reset in Stop-Grant entered from Halt
        cyc(); halt_stb = 1; exp("R2", 3'd1, 0, 4'h0, 0);
        go_grant();
        cyc(); smi = 1; exp("R9", 3'd2, 0, 4'h0, 0);
        cyc(); core_reset = 1; exp("R9", 3'd2, 0, 4'h0, 0);
        cyc(); stpclk_n = 1; exp("R9", 3'd0, 0, 4'h0, 0);

        // R9 reset in Halt and in Sleep
        cyc(); halt_stb = 1; exp("R2", 3'd1, 0, 4'h0, 0);
        cyc(); core_reset = 1; exp("R9", 3'd0, 0, 4'h0, 0);
        go_grant();
        cyc(); slp_n = 0; exp("R5", 3'd4, 0, 4'h0, 0);
        cyc(); core_reset = 1; slp_n = 1; stpclk_n = 1; exp("R9", 3'd0, 0, 4'h0, 0);
        cyc(); exp("R1", 3'd0, 0, 4'h0, 0);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule